// File: doc/BRIEF.md
# Dual-output masked interrupt controller

This block gathers up to 32 level-sensitive interrupt sources into one raw level vector. It drives two request lines to a processor: a normal request and a fast request. Each line has its own enable mask. A line is raised whenever at least one raw source that its mask enables is high. Software changes the masks through separate set and clear addresses, so one mask bit can be changed without a read-modify-write. Software can also raise source 0 on its own, which is useful for a self-interrupt or for testing the request path.

Software reaches the block through a simple word-addressed register bus. A read returns data combinationally in the same cycle. A write takes effect at the clock edge. The raw vector is not latched: it follows the input pins, except that bit 0 is the OR of input 0 and the software bit. The controller has no priority, no vectoring and no edge capture. A source that stays high keeps its request asserted until the source drops or its enable bit is cleared.

Top module: `irqc_top`

## Requirements
- R1: After reset both enable masks and the software source bit are zero, and both request outputs are low.
- R2: The normal request output equals the OR of (raw AND normal mask) as it stood in the previous clock cycle (one register stage).
- R3: The fast request output equals the OR of (raw AND fast mask) as it stood in the previous clock cycle.
- R4: Writing offset 2 ORs the write data into the normal mask. Writing offset 3 clears every normal mask bit that is 1 in the data. Reading offset 2 returns the normal mask.
- R5: Writing offset 10 ORs the data into the fast mask. Writing offset 11 clears the fast mask bits that are 1 in the data. Reading offset 10 returns the fast mask.
- R6: Reading offset 0 returns raw AND normal mask. Reading offset 8 returns raw AND fast mask. Reading offset 1 or offset 9 returns the raw vector.
- R7: A write to offset 4 with data bit 0 = 1 sets the software bit. A write to offset 5 with data bit 0 = 1 clears it. A write with data bit 0 = 0 has no effect on it. Reading offset 4 returns raw bit 0 in bit 0 and zeros above it.
- R8: Raw bit n follows input n with no latching, so a source that goes low clears its raw bit at once. Raw bit 0 is input 0 OR the software bit.
- R9: Reads of offsets 3, 5 and 11, and of any unmapped offset, return zero. Writes to offsets 0, 1, 8 and 9, and to unmapped offsets, leave both masks and the software bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Level interrupt sources |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the same cycle as the access |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The directed tests use several source patterns: a single enabled source, a source that is high but masked, one source enabled on both outputs at once, and a source that drops while it is still enabled. Together these separate the masking from the raw path and from latching. The tests cover soft-set and soft-clear writes with data bit 0 set and with it clear, so a decoder that ignores bit 0 shows up. They also cover writes to the status addresses and reads of the clear addresses. A long run of random accesses over all sixteen offsets follows. A behavioural model predicts every read word and both request lines on every clock, so a wrong offset, a swapped mask or a missing output register shows up as a mismatch.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int ADDR_W = 4;
   localparam logic [ADDR_W-1:0] OFS_NSTAT   = 4'd0;
   localparam logic [ADDR_W-1:0] OFS_NRAW    = 4'd1;
   localparam logic [ADDR_W-1:0] OFS_NEN_SET = 4'd2;
   localparam logic [ADDR_W-1:0] OFS_NEN_CLR = 4'd3;
   localparam logic [ADDR_W-1:0] OFS_SW_SET  = 4'd4;
   localparam logic [ADDR_W-1:0] OFS_SW_CLR  = 4'd5;
   localparam logic [ADDR_W-1:0] OFS_FSTAT   = 4'd8;
   localparam logic [ADDR_W-1:0] OFS_FRAW    = 4'd9;
   localparam logic [ADDR_W-1:0] OFS_FEN_SET = 4'd10;
   localparam logic [ADDR_W-1:0] OFS_FEN_CLR = 4'd11;
   localparam int NUM_OUT = 2;
endpackage

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] mask_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mask_o <= '0;
      else if (set_we) mask_o <= mask_o | wdata;
      else if (clr_we) mask_o <= mask_o & ~wdata;
   end

   a_r4_r5_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((mask_o & $past(wdata)) == $past(wdata)));
   a_r4_r5_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !set_we) |=> ((mask_o & $past(wdata)) == '0));
   a_r4_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we && !clr_we) |=> $stable(mask_o));
endmodule

// File: rtl/irqc_soft_src.sv
module irqc_soft_src (
   input  logic clk,
   input  logic rst_n,
   input  logic set_we,
   input  logic clr_we,
   input  logic bit0,
   output logic soft_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                soft_o <= 1'b0;
      else if (set_we && bit0)   soft_o <= 1'b1;
      else if (clr_we && bit0)   soft_o <= 1'b0;
   end

   a_r7_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we && bit0) |=> soft_o);
   a_r7_soft_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && bit0 && !set_we) |=> !soft_o);
   a_r7_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
      !bit0 |=> $stable(soft_o));
endmodule

// File: rtl/irqc_out_stage.sv
module irqc_out_stage #(
   parameter int W       = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw,
   input  logic [W-1:0] mask,
   output logic         req_o
);
   logic hit;
   assign hit = |(raw & mask);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) req_o <= 1'b0;
         else        req_o <= hit;
      end
      a_r2_r3_follow: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (req_o == $past(|(raw & mask))));
   end else begin : g_comb
      assign req_o = hit;
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
   end
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
   parameter int NUM_SRC = 32,
   parameter int DATA_W  = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_SRC-1:0]          src_i,
   input  logic                        bus_sel,
   input  logic                        bus_wr,
   input  logic [irqc_pkg::ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0]           bus_wdata,
   output logic [DATA_W-1:0]           bus_rdata,
   output logic                        irq_o,
   output logic                        fiq_o
);
   import irqc_pkg::*;

   initial begin
      if (NUM_SRC < 1 || NUM_SRC > DATA_W)
         $error("irqc_top: NUM_SRC must lie in 1..DATA_W");
   end

   localparam logic [ADDR_W-1:0] SET_OFS [NUM_OUT] = '{OFS_NEN_SET, OFS_FEN_SET};
   localparam logic [ADDR_W-1:0] CLR_OFS [NUM_OUT] = '{OFS_NEN_CLR, OFS_FEN_CLR};

   logic               wr_hit;
   logic               rd_hit;
   logic               soft_q;
   logic [NUM_SRC-1:0] raw;
   logic [NUM_SRC-1:0] en_q  [NUM_OUT];
   logic [NUM_OUT-1:0] req;

   assign wr_hit = bus_sel &&  bus_wr;
   assign rd_hit = bus_sel && !bus_wr;

   irqc_soft_src u_soft (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (wr_hit && bus_addr == OFS_SW_SET),
      .clr_we (wr_hit && bus_addr == OFS_SW_CLR),
      .bit0   (bus_wdata[0]),
      .soft_o (soft_q)
   );

   if (NUM_SRC > 1) begin : g_raw_wide
      assign raw = {src_i[NUM_SRC-1:1], src_i[0] | soft_q};
   end else begin : g_raw_one
      assign raw = src_i | soft_q;
   end

   for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
      irqc_mask_reg #(.W(NUM_SRC)) u_mask (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_we (wr_hit && bus_addr == SET_OFS[g]),
         .clr_we (wr_hit && bus_addr == CLR_OFS[g]),
         .wdata  (bus_wdata[NUM_SRC-1:0]),
         .mask_o (en_q[g])
      );
      irqc_out_stage #(.W(NUM_SRC), .REG_OUT(REG_OUT)) u_stage (
         .clk   (clk),
         .rst_n (rst_n),
         .raw   (raw),
         .mask  (en_q[g]),
         .req_o (req[g])
      );
   end

   assign irq_o = req[0];
   assign fiq_o = req[1];

   always_comb begin
      bus_rdata = '0;
      if (rd_hit) begin
         case (bus_addr)
            OFS_NSTAT:           bus_rdata = DATA_W'(raw & en_q[0]);
            OFS_NRAW, OFS_FRAW:  bus_rdata = DATA_W'(raw);
            OFS_NEN_SET:         bus_rdata = DATA_W'(en_q[0]);
            OFS_SW_SET:          bus_rdata = DATA_W'(raw[0]);
            OFS_FSTAT:           bus_rdata = DATA_W'(raw & en_q[1]);
            OFS_FEN_SET:         bus_rdata = DATA_W'(en_q[1]);
            default:             bus_rdata = '0;
         endcase
      end
   end

   a_r9_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && (bus_addr == OFS_NSTAT || bus_addr == OFS_NRAW ||
                  bus_addr == OFS_FSTAT || bus_addr == OFS_FRAW))
      |=> ($stable(en_q[0]) && $stable(en_q[1]) && $stable(soft_q)));
   a_r9_clear_addr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && (bus_addr == OFS_NEN_CLR || bus_addr == OFS_SW_CLR ||
                  bus_addr == OFS_FEN_CLR)) |-> (bus_rdata == '0));
   a_r7_soft_read_narrow: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && bus_addr == OFS_SW_SET) |-> (bus_rdata[DATA_W-1:1] == '0));
   a_r8_raw_tracks_pins: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && bus_addr == OFS_NRAW) |-> ((bus_rdata[NUM_SRC-1:0] & ~NUM_SRC'(1)) ==
                                            (src_i & ~NUM_SRC'(1))));
endmodule

// File: tb/irqc_top_bench.sv
`timescale 1ns/1ps
module irqc_top_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_i = '0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o, fiq_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // reference state
   logic [31:0] m_nen = '0;
   logic [31:0] m_fen = '0;
   logic        m_soft = 1'b0;

   always #10 clk = ~clk;

   irqc_top u_irqc_top (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o), .fiq_o(fiq_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] model_read(input logic [3:0] a, input logic [31:0] raw);
      case (a)
         4'd0:       return raw & m_nen;
         4'd1, 4'd9: return raw;
         4'd2:       return m_nen;
         4'd4:       return {31'b0, raw[0]};
         4'd8:       return raw & m_fen;
         4'd10:      return m_fen;
         default:    return 32'h0;
      endcase
   endfunction

   // one clock: drive at negedge, check read, predict outputs, check after edge
   task automatic step(input string tag, input logic s, input logic w, input logic [3:0] a,
                       input logic [31:0] d, input logic [31:0] src);
      logic [31:0] raw;
      logic        e_irq, e_fiq;
      bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; src_i = src;
      #2;
      raw = src | {31'b0, m_soft};
      if (s && !w) check(tag, bus_rdata, model_read(a, raw));
      e_irq = |(raw & m_nen);
      e_fiq = |(raw & m_fen);
      if (s && w) begin
         case (a)
            4'd2:  m_nen = m_nen | d;
            4'd3:  m_nen = m_nen & ~d;
            4'd4:  if (d[0]) m_soft = 1'b1;
            4'd5:  if (d[0]) m_soft = 1'b0;
            4'd10: m_fen = m_fen | d;
            4'd11: m_fen = m_fen & ~d;
            default: ;
         endcase
      end
      @(posedge clk); #2;
      check("R2 irq_o", {31'b0, irq_o}, {31'b0, e_irq});
      check("R3 fiq_o", {31'b0, fiq_o}, {31'b0, e_fiq});
      @(negedge clk);
   endtask

   task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] src);
      step(tag, 1'b1, 1'b0, a, 32'h0, src);
   endtask

   task automatic wr(input string tag, input logic [3:0] a, input logic [31:0] d,
                     input logic [31:0] src);
      step(tag, 1'b1, 1'b1, a, d, src);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 irq_o in reset", {31'b0, irq_o}, 32'h0);
      check("R1 fiq_o in reset", {31'b0, fiq_o}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      rd("R1 normal mask", 4'd2, 32'hFFFF_FFFF);
      rd("R1 fast mask", 4'd10, 32'h0);
      rd("R1 soft bit", 4'd4, 32'h0);

      // normal mask set / clear
      wr("R4 set", 4'd2, 32'h0000_00F0, 32'h0);
      rd("R4 read", 4'd2, 32'h0);
      step("R2 single enabled", 1'b0, 1'b0, 4'd0, 32'h0, 32'h10);
      step("R2 hold", 1'b0, 1'b0, 4'd0, 32'h0, 32'h10);
      rd("R6 normal status", 4'd0, 32'h0000_0110);
      rd("R6 raw via 1", 4'd1, 32'h0000_0110);
      wr("R4 clear", 4'd3, 32'h0000_0030, 32'h10);
      rd("R4 after clear", 4'd2, 32'h10);
      step("R2 masked source", 1'b0, 1'b0, 4'd0, 32'h0, 32'h10);

      // fast mask
      wr("R5 set", 4'd10, 32'h8000_0041, 32'h0);
      step("R3 enabled on both", 1'b0, 1'b0, 4'd0, 32'h0, 32'h8000_0040);
      rd("R6 fast status", 4'd8, 32'h8000_0040);
      rd("R6 raw via 9", 4'd9, 32'h8000_0040);
      rd("R5 read", 4'd10, 32'h8000_0040);
      wr("R5 clear", 4'd11, 32'h8000_0000, 32'h8000_0040);
      rd("R5 after clear", 4'd10, 32'h0);

      // soft source
      wr("R7 set with bit0 low", 4'd4, 32'h0000_0002, 32'h0);
      rd("R7 unchanged", 4'd4, 32'h0);
      wr("R7 set", 4'd4, 32'h0000_0001, 32'h0);
      rd("R7 read narrow", 4'd4, 32'h0);
      rd("R8 raw bit0 from soft", 4'd1, 32'h0000_0004);
      wr("R7 clear with bit0 low", 4'd5, 32'hFFFF_FFFE, 32'h0);
      rd("R7 still set", 4'd4, 32'h0);
      wr("R7 clear", 4'd5, 32'h0000_0001, 32'h0);
      rd("R7 cleared", 4'd4, 32'h0);
      rd("R8 pin0 alone", 4'd4, 32'h0000_0001);

      // raw follows pins
      wr("R8 enable bit2", 4'd2, 32'h0000_0004, 32'h4);
      step("R8 source high", 1'b0, 1'b0, 4'd0, 32'h0, 32'h4);
      step("R8 source drops", 1'b0, 1'b0, 4'd0, 32'h0, 32'h0);
      rd("R8 raw cleared", 4'd1, 32'h0);

      // ignored writes / zero reads
      rd("R9 read 3", 4'd3, 32'hFFFF_FFFF);
      rd("R9 read 5", 4'd5, 32'hFFFF_FFFF);
      rd("R9 read 11", 4'd11, 32'hFFFF_FFFF);
      rd("R9 read unmapped", 4'd14, 32'hFFFF_FFFF);
      wr("R9 write 0", 4'd0, 32'hFFFF_FFFF, 32'h0);
      wr("R9 write 1", 4'd1, 32'hFFFF_FFFF, 32'h0);
      wr("R9 write 8", 4'd8, 32'hFFFF_FFFF, 32'h0);
      wr("R9 write 9", 4'd9, 32'hFFFF_FFFF, 32'h0);
      rd("R9 normal mask kept", 4'd2, 32'h0);
      rd("R9 fast mask kept", 4'd10, 32'h0);
      rd("R9 soft kept", 4'd4, 32'h0);

      // random traffic against the model
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] d = $urandom;
         logic [31:0] s = $urandom & $urandom;
         logic [3:0]  a = 4'($urandom);
         logic        sel = ($urandom % 4) != 0;
         logic        w = $urandom % 2;
         step("R6 random", sel, w, a, d, s);
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule